// File: doc/BRIEF.md
# Multi-Master Semaphore Gate Bank

This block lets several bus masters share sixteen hardware lock gates. Every master has its own access port with a write strobe, a word address, write data and combinational read data. The master's identity comes from which port it uses. A master takes a free gate by writing its own lock code to that gate's address. Only the master that holds a gate can give it back. Any master can read a gate to see who holds it.

Two keyed reset sequencers work independently of each other. One frees a single gate or every gate. The other clears the notification state for a single gate or for every gate. Each sequencer needs two writes in a row, both from the same master, and it reports which master is running it.

When a master tries to take a gate and is refused, the bank remembers that request. When the gate is later freed, the bank raises a notification flag for that master. Each master has its own interrupt line, which follows its flags masked by its own enables.

Top module: `hsem_bank`

## Requirements
- R1: After a synchronous active-low reset:
  - every gate address (0 to 15) reads 0x00FF, meaning no owner;
  - both sequencer status words read 0;
  - every flag word and every enable word reads 0;
  - every interrupt line is low.
- R2: When master k writes the value k+1 (in bits [7:0]) to a free gate, the gate reads k from the next cycle on.
- R3: These writes leave the gate's reading unchanged:
  - a lock write to a gate that another master holds;
  - a write to a gate of any value other than k+1 or 0 from master k.
- R4: A gate returns to 0x00FF only when its holder writes 0 to it. A zero written by any other master is ignored.
- R5: If several masters write their lock codes to the same free gate in one cycle, the lowest-numbered master takes the gate.
- R6: Gate-reset sequencer, written at address 16:
  - Bits [7:0] carry the key and bits [15:8] carry the gate number.
  - A write of key 0xE2 moves it from idle to armed and records the writer.
  - A following write of key 0x1D from the same master runs the reset. Gate numbers 0 to 15 free that gate. A gate number of 64 or more frees all gates.
  - The gate reads 0x00FF two cycles after the second write.
  - The status word shows the state in bits [5:4] (0 idle, 1 armed) and the recorded master in bits [2:0].
  - The one-cycle finishing state reads as idle.
- R7: While the gate-reset sequencer is armed, it returns to idle without freeing anything if it receives either of these:
  - a write from a different master;
  - a write with a key other than 0x1D.
- R8: A refused lock attempt arms that master's notification for the gate, including a loss under R5. When the gate is next freed, by release or by reset, the master's flag is set.
  - The flag word (address 18, read by each master for itself) places gate n at bit n XOR 7.
  - Examples: gate 0 is bit 7, gate 8 is bit 15, gate 9 is bit 14.
- R9: Interrupt enables use the same bit order as the flag word.
  - A write to address 19 sets the enable bits selected by the mask.
  - A write to address 20 clears the enable bits selected by the mask.
  - Unmasked bits and other masters' enables are unchanged.
  - Both addresses read back the writer's enables.
  - A master's interrupt is high when any flag bit and its enable bit are both set.
- R10: A second sequencer at address 17 uses the same keys, data layout and status layout. It clears the flags and armed notifications of all masters for one gate, or for all gates when the gate number is 64 or more. It does not disturb the gate-reset sequencer.
- R11: A master that takes a gate clears its own flag for that gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | NUM_MASTERS | Per-master access strobe |
| bus_we | input | NUM_MASTERS | Per-master write qualifier |
| bus_addr | input | 5*NUM_MASTERS | Per-master word address, master m at bits [5m+4:5m] |
| bus_wdata | input | 16*NUM_MASTERS | Per-master write data, master m at bits [16m+15:16m] |
| bus_rdata | output | 16*NUM_MASTERS | Per-master read data for the addressed word, combinational |
| irq | output | NUM_MASTERS | Per-master notification interrupt |

## Verification
A wrong owner code shows up right away: the holder's reading changes, or two masters both receive grants, and both are visible on the next read of the gate. A sequencer stuck in the wrong state shows in its status word on the following cycle. It also shows as a gate that should have stayed held reading 0x00FF one cycle later, so the bench reads gates again right after every aborted sequence. A notification that is armed but has lost its record stays hidden until the gate is freed. For that reason the flag words and interrupt lines are checked in the cycle right after each release and each reset.

// File: rtl/hsem_pkg.sv
// Shared constants, state type and bit-order helpers for the semaphore gate bank.
// Assumes 16 gates and at most 8 masters (3-bit master number in status words).
package hsem_pkg;
    localparam int GATES = 16;
    localparam int GW    = 4;          // gate index width
    localparam int IDW   = 3;          // master number width in status words
    localparam int CW    = IDW + 1;    // owner code width: 0 free, k+1 held by k
    localparam int AW    = 5;          // word address width
    localparam int DW    = 16;         // data width

    localparam logic [7:0] KEY_ARM  = 8'hE2;
    localparam logic [7:0] KEY_FIRE = 8'h1D;
    localparam logic [7:0] TGT_ALL  = 8'd64;
    localparam logic [7:0] NO_OWNER = 8'hFF;

    localparam logic [AW-1:0] A_GSEQ  = 5'd16;
    localparam logic [AW-1:0] A_NSEQ  = 5'd17;
    localparam logic [AW-1:0] A_FLAG  = 5'd18;
    localparam logic [AW-1:0] A_IESET = 5'd19;
    localparam logic [AW-1:0] A_IECLR = 5'd20;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MID  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // Swap gate order with flag-word order (gate n <-> bit n^7); self-inverse.
    function automatic logic [GATES-1:0] swizzle(input logic [GATES-1:0] v);
        logic [GATES-1:0] r;
        for (int n = 0; n < GATES; n++) begin
            r[n ^ 7] = v[n];
        end
        return r;
    endfunction

    // Turn a sequencer firing and its gate number into a per-gate select mask.
    function automatic logic [GATES-1:0] target_mask(input logic fire, input logic [7:0] tgt);
        logic [GATES-1:0] r;
        r = '0;
        if (fire) begin
            if (tgt >= TGT_ALL) begin
                r = '1;
            end else if (tgt < 8'(GATES)) begin
                r[tgt[GW-1:0]] = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/hsem_key_seq.sv
// Two-write keyed sequencer. An arming key moves idle to armed and records the
// writer. A firing key from that same master moves armed to done for one cycle,
// which pulses fire_o. Any other write while armed goes back to idle. When
// several masters write in one cycle, the lowest-numbered one is taken.
// Assumes NM <= 8.
module hsem_key_seq
    import hsem_pkg::*;
#(
    parameter int NM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          wr_vld,
    input  logic [NM-1:0][DW-1:0]  wr_data,
    output seq_state_e             state_o,
    output logic                   fire_o,
    output logic [7:0]             tgt_o,
    output logic [DW-1:0]          status_o
);
    seq_state_e       st_q, st_d;
    logic [IDW-1:0]   own_q, own_d;
    logic [7:0]       tgt_q, tgt_d;
    logic             pick_v;
    logic [IDW-1:0]   pick_m;
    logic [DW-1:0]    pick_d;
    logic [1:0]       vis_state;

    // Pick the lowest-numbered master writing this cycle.
    always_comb begin
        pick_v = 1'b0;
        pick_m = '0;
        pick_d = '0;
        for (int m = NM - 1; m >= 0; m--) begin
            if (wr_vld[m]) begin
                pick_v = 1'b1;
                pick_m = IDW'(m);
                pick_d = wr_data[m];
            end
        end
    end

    // Next-state rules for the keyed sequence.
    always_comb begin
        st_d  = st_q;
        own_d = own_q;
        tgt_d = tgt_q;
        case (st_q)
            SEQ_IDLE: begin
                if (pick_v && pick_d[7:0] == KEY_ARM) begin
                    st_d  = SEQ_MID;
                    own_d = pick_m;
                    tgt_d = pick_d[15:8];
                end
            end
            SEQ_MID: begin
                if (pick_v) begin
                    if (pick_d[7:0] == KEY_FIRE && pick_m == own_q) begin
                        st_d  = SEQ_DONE;
                        tgt_d = pick_d[15:8];
                    end else begin
                        st_d = SEQ_IDLE;
                    end
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // State, recorded master and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            own_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
            tgt_q <= tgt_d;
        end
    end

    // The done state is reported as idle so that no reader ever sees it.
    assign vis_state = (st_q == SEQ_DONE) ? 2'd0 : st_q;
    assign state_o   = st_q;
    assign fire_o    = (st_q == SEQ_DONE);
    assign tgt_o     = tgt_q;
    assign status_o  = {10'd0, vis_state, 1'b0, own_q};
endmodule

// File: rtl/hsem_gate_bank.sv
// Owner registers for all gates, with lock and release arbitration. Each gate
// holds a code: 0 means free, k+1 means held by master k. A reset mask frees
// gates and takes precedence; lock attempts on a masked gate are dropped.
// Outputs per-master take and refusal strobes, plus a per-gate freeing event.
module hsem_gate_bank
    import hsem_pkg::*;
#(
    parameter int NM = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NM-1:0]              wr_vld,
    input  logic [NM-1:0][GW-1:0]      wr_gate,
    input  logic [NM-1:0][7:0]         wr_val,
    input  logic [GATES-1:0]           rst_mask,
    output logic [GATES-1:0][CW-1:0]   code_o,
    output logic [GATES-1:0]           free_o,
    output logic [NM-1:0][GATES-1:0]   arm_o,
    output logic [NM-1:0][GATES-1:0]   take_o
);
    logic [GATES-1:0][CW-1:0] code_q, code_d;
    logic                     held_c;
    logic [IDW-1:0]           own_c;
    logic                     rel_c;
    logic                     got_c;
    logic [NM-1:0]            lk_c;

    // Resolve lock, release and reset for every gate.
    always_comb begin
        code_d = code_q;
        free_o = '0;
        arm_o  = '0;
        take_o = '0;
        held_c = 1'b0;
        own_c  = '0;
        rel_c  = 1'b0;
        got_c  = 1'b0;
        lk_c   = '0;
        for (int g = 0; g < GATES; g++) begin
            held_c = (code_q[g] != '0);
            own_c  = IDW'(code_q[g] - 1'b1);
            rel_c  = 1'b0;
            got_c  = 1'b0;
            for (int m = 0; m < NM; m++) begin
                lk_c[m] = wr_vld[m] && (wr_gate[m] == GW'(g)) && (wr_val[m] == 8'(m + 1));
                if (wr_vld[m] && (wr_gate[m] == GW'(g)) && (wr_val[m] == 8'd0)
                    && held_c && (own_c == IDW'(m))) begin
                    rel_c = 1'b1;
                end
            end
            if (rst_mask[g]) begin
                code_d[g] = '0;
                free_o[g] = held_c;
            end else if (held_c) begin
                if (rel_c) begin
                    code_d[g] = '0;
                    free_o[g] = 1'b1;
                end
                for (int m = 0; m < NM; m++) begin
                    if (lk_c[m] && (own_c != IDW'(m))) begin
                        arm_o[m][g] = 1'b1;
                    end
                end
            end else begin
                for (int m = 0; m < NM; m++) begin
                    if (lk_c[m]) begin
                        if (!got_c) begin
                            got_c        = 1'b1;
                            take_o[m][g] = 1'b1;
                            code_d[g]    = CW'(m + 1);
                        end else begin
                            arm_o[m][g] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Owner code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/hsem_notify.sv
// Per-master notification state, kept in gate order. A refusal marks the gate
// as pending for that master. When the gate is freed, pending (or refused in
// that same cycle) becomes a flag. A take clears the taker's own entries.
// The clear mask wipes every master's entries for the selected gates.
// Interrupt enables are set or cleared under a mask.
module hsem_notify
    import hsem_pkg::*;
#(
    parameter int NM = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GATES-1:0]           free_i,
    input  logic [NM-1:0][GATES-1:0]   arm_i,
    input  logic [NM-1:0][GATES-1:0]   take_i,
    input  logic [GATES-1:0]           clr_i,
    input  logic [NM-1:0]              ie_set_i,
    input  logic [NM-1:0]              ie_clr_i,
    input  logic [NM-1:0][GATES-1:0]   ie_mask_i,
    output logic [NM-1:0][GATES-1:0]   flag_o,
    output logic [NM-1:0][GATES-1:0]   ie_o,
    output logic [NM-1:0]              irq_o
);
    logic [NM-1:0][GATES-1:0] pend_q, flag_q, ie_q;

    // Pending and flag update, with clear taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            flag_q <= '0;
        end else begin
            for (int m = 0; m < NM; m++) begin
                flag_q[m] <= (flag_q[m] | ((pend_q[m] | arm_i[m]) & free_i))
                             & ~take_i[m] & ~clr_i;
                pend_q[m] <= (pend_q[m] | arm_i[m]) & ~free_i & ~take_i[m] & ~clr_i;
            end
        end
    end

    // Masked set and clear of interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else begin
            for (int m = 0; m < NM; m++) begin
                if (ie_set_i[m]) begin
                    ie_q[m] <= ie_q[m] | ie_mask_i[m];
                end else if (ie_clr_i[m]) begin
                    ie_q[m] <= ie_q[m] & ~ie_mask_i[m];
                end
            end
        end
    end

    genvar gm;
    generate
        for (gm = 0; gm < NM; gm++) begin : g_irq
            assign irq_o[gm] = |(flag_q[gm] & ie_q[gm]);
        end
    endgenerate

    assign flag_o = flag_q;
    assign ie_o   = ie_q;
endmodule

// File: rtl/hsem_bank.sv
// Top level of the semaphore gate bank. It decodes each master's port into
// gate, sequencer and enable accesses, instantiates the gate array, both keyed
// sequencers and the notification store, and drives the per-master read mux.
// Address map: 0-15 gates, 16 gate reset, 17 notification reset, 18 flags,
// 19 enable set, 20 enable clear. Assumes NUM_MASTERS <= 8.
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        bus_en,
    input  logic [NUM_MASTERS-1:0]        bus_we,
    input  logic [NUM_MASTERS*AW-1:0]     bus_addr,
    input  logic [NUM_MASTERS*DW-1:0]     bus_wdata,
    output logic [NUM_MASTERS*DW-1:0]     bus_rdata,
    output logic [NUM_MASTERS-1:0]        irq
);
    localparam int NM = NUM_MASTERS;

    logic [NM-1:0][AW-1:0]     addr_m;
    logic [NM-1:0][DW-1:0]     wdata_m;
    logic [NM-1:0][DW-1:0]     rdata_m;
    logic [NM-1:0]             wr_m;
    logic [NM-1:0]             gwr_v, gseq_v, nseq_v, ieset_v, ieclr_v;
    logic [NM-1:0][GW-1:0]     gwr_idx;
    logic [NM-1:0][7:0]        gwr_val;
    logic [NM-1:0][GATES-1:0]  ie_mask;

    logic [GATES-1:0][CW-1:0]  gate_code;
    logic [GATES-1:0]          free_evt;
    logic [NM-1:0][GATES-1:0]  arm_v, take_v, flag_q, ie_q;
    logic [GATES-1:0]          gate_rst_mask, ntf_clr_mask;

    seq_state_e                gseq_state, nseq_state;
    logic                      gseq_fire, nseq_fire;
    logic [7:0]                gseq_tgt, nseq_tgt;
    logic [DW-1:0]             gseq_status, nseq_status;

    genvar gm;
    generate
        for (gm = 0; gm < NM; gm++) begin : g_port
            logic [CW-1:0] sel_code;

            assign addr_m[gm]  = bus_addr[gm*AW +: AW];
            assign wdata_m[gm] = bus_wdata[gm*DW +: DW];
            assign bus_rdata[gm*DW +: DW] = rdata_m[gm];

            assign wr_m[gm]    = bus_en[gm] & bus_we[gm];
            assign gwr_v[gm]   = wr_m[gm] & ~addr_m[gm][AW-1];
            assign gseq_v[gm]  = wr_m[gm] & (addr_m[gm] == A_GSEQ);
            assign nseq_v[gm]  = wr_m[gm] & (addr_m[gm] == A_NSEQ);
            assign ieset_v[gm] = wr_m[gm] & (addr_m[gm] == A_IESET);
            assign ieclr_v[gm] = wr_m[gm] & (addr_m[gm] == A_IECLR);
            assign gwr_idx[gm] = addr_m[gm][GW-1:0];
            assign gwr_val[gm] = wdata_m[gm][7:0];
            assign ie_mask[gm] = swizzle(wdata_m[gm]);
            assign sel_code    = gate_code[addr_m[gm][GW-1:0]];

            // Read mux for this master's addressed word.
            always_comb begin
                if (!addr_m[gm][AW-1]) begin
                    rdata_m[gm] = (sel_code == '0) ? {8'h00, NO_OWNER}
                                                   : DW'(sel_code - 1'b1);
                end else begin
                    case (addr_m[gm])
                        A_GSEQ:  rdata_m[gm] = gseq_status;
                        A_NSEQ:  rdata_m[gm] = nseq_status;
                        A_FLAG:  rdata_m[gm] = swizzle(flag_q[gm]);
                        A_IESET: rdata_m[gm] = swizzle(ie_q[gm]);
                        A_IECLR: rdata_m[gm] = swizzle(ie_q[gm]);
                        default: rdata_m[gm] = '0;
                    endcase
                end
            end
        end
    endgenerate

    assign gate_rst_mask = target_mask(gseq_fire, gseq_tgt);
    assign ntf_clr_mask  = target_mask(nseq_fire, nseq_tgt);

    hsem_key_seq #(.NM(NM)) u_gate_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (gseq_v),
        .wr_data  (wdata_m),
        .state_o  (gseq_state),
        .fire_o   (gseq_fire),
        .tgt_o    (gseq_tgt),
        .status_o (gseq_status)
    );

    hsem_key_seq #(.NM(NM)) u_ntf_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (nseq_v),
        .wr_data  (wdata_m),
        .state_o  (nseq_state),
        .fire_o   (nseq_fire),
        .tgt_o    (nseq_tgt),
        .status_o (nseq_status)
    );

    hsem_gate_bank #(.NM(NM)) u_gates (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (gwr_v),
        .wr_gate  (gwr_idx),
        .wr_val   (gwr_val),
        .rst_mask (gate_rst_mask),
        .code_o   (gate_code),
        .free_o   (free_evt),
        .arm_o    (arm_v),
        .take_o   (take_v)
    );

    hsem_notify #(.NM(NM)) u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .free_i    (free_evt),
        .arm_i     (arm_v),
        .take_i    (take_v),
        .clr_i     (ntf_clr_mask),
        .ie_set_i  (ieset_v),
        .ie_clr_i  (ieclr_v),
        .ie_mask_i (ie_mask),
        .flag_o    (flag_q),
        .ie_o      (ie_q),
        .irq_o     (irq)
    );
endmodule

// File: rtl/hsem_chk.sv
// Property checker for hsem_bank, attached by bind. It watches owner codes,
// sequencer states, freeing events and notification flags over time.
module hsem_chk
    import hsem_pkg::*;
#(
    parameter int NM = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NM-1:0]             bus_en,
    input logic [NM-1:0]             bus_we,
    input logic [GATES-1:0][CW-1:0]  gate_code,
    input logic [1:0]                gseq_state,
    input logic [1:0]                nseq_state,
    input logic [GATES-1:0]          free_evt,
    input logic [NM-1:0][GATES-1:0]  flag_q
);
    genvar gg, gm;
    generate
        for (gg = 0; gg < GATES; gg++) begin : g_gate
            AST_HELD_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
                (gate_code[gg] != '0 && $past(gate_code[gg]) != '0) |-> gate_code[gg] == $past(gate_code[gg]))
                else $error("held gate changed owner"); // R3
            AST_FREE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(gate_code[gg] != '0) |-> ($past(gseq_state) == 2'd2 || $past(|(bus_en & bus_we))))
                else $error("gate freed without release or reset"); // R4
            for (gm = 0; gm < NM; gm++) begin : g_m
                AST_FLAG_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(flag_q[gm][gg]) |-> $past(free_evt[gg]))
                    else $error("flag rose without a freeing event"); // R8
            end
        end
    endgenerate

    AST_GSEQ_DONE_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
        gseq_state == 2'd2 |-> $past(gseq_state) == 2'd1)
        else $error("gate sequencer skipped armed state"); // R6
    AST_GSEQ_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        gseq_state == 2'd2 |=> gseq_state == 2'd0)
        else $error("gate sequencer stayed in done"); // R6
    AST_NSEQ_DONE_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
        nseq_state == 2'd2 |-> $past(nseq_state) == 2'd1)
        else $error("notification sequencer skipped armed state"); // R10
    AST_NO_BAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        gseq_state != 2'd3 && nseq_state != 2'd3)
        else $error("sequencer in unused encoding"); // R7
endmodule

bind hsem_bank hsem_chk #(.NM(NUM_MASTERS)) u_hsem_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .gate_code  (gate_code),
    .gseq_state (gseq_state),
    .nseq_state (nseq_state),
    .free_evt   (free_evt),
    .flag_q     (flag_q)
);

// File: tb/hsem_bank_bench.sv
`timescale 1ns/1ps
module hsem_bank_bench;
    localparam int NM = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     bus_en = '0;
    logic [NM-1:0]     bus_we = '0;
    logic [NM*5-1:0]   bus_addr = '0;
    logic [NM*16-1:0]  bus_wdata = '0;
    logic [NM*16-1:0]  bus_rdata;
    logic [NM-1:0]     irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    int          q_m[$];
    logic [15:0] q_e[$];
    string       q_t[$];

    always #2.5 clk = ~clk;

    hsem_bank #(.NUM_MASTERS(NM)) u_hsem_bank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic put(input int m, input int a, input logic [15:0] d);
        bus_en[m] = 1'b1;
        bus_we[m] = 1'b1;
        bus_addr[m*5 +: 5]   = 5'(a);
        bus_wdata[m*16 +: 16] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        bus_en = '0;
        bus_we = '0;
    endtask

    // Driver: point master m at address a, queue the expected read value.
    task automatic chk(input int m, input int a, input logic [15:0] e, input string tag);
        bus_addr[m*5 +: 5] = 5'(a);
        q_m.push_back(m);
        q_e.push_back(e);
        q_t.push_back(tag);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic [NM-1:0] e, input string tag);
        q_m.push_back(-1);
        q_e.push_back(16'(e));
        q_t.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: pop queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_m.size() > 0) begin
                int m;
                logic [15:0] e, act;
                string t;
                m = q_m.pop_front();
                e = q_e.pop_front();
                t = q_t.pop_front();
                act = (m < 0) ? 16'(irq) : bus_rdata[m*16 +: 16];
                checks++;
                if (act !== e) begin
                    errs++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 0, 16'h00FF, "R1 gate0");
        chk(1, 15, 16'h00FF, "R1 gate15");
        chk(2, 16, 16'h0000, "R1 gate seq status");
        chk(3, 17, 16'h0000, "R1 ntf seq status");
        chk(0, 18, 16'h0000, "R1 flags");
        chk(1, 19, 16'h0000, "R1 enables");
        chk_irq(4'b0000, "R1 irq");
        // R2 lock
        put(1, 3, 16'd2); step();
        chk(0, 3, 16'h0001, "R2 m1 owns gate3");
        put(3, 15, 16'd4); step();
        chk(0, 15, 16'h0003, "R2 m3 owns gate15");
        // R3 refused and malformed writes
        put(2, 3, 16'd3); step();
        chk(3, 3, 16'h0001, "R3 held gate unchanged");
        put(0, 4, 16'd5); step();
        chk(0, 4, 16'h00FF, "R3 wrong code ignored");
        // R4 release only by holder
        put(2, 3, 16'd0); step();
        chk(2, 3, 16'h0001, "R4 non-owner zero ignored");
        put(1, 3, 16'd0); step();
        chk(1, 3, 16'h00FF, "R4 owner release");
        // R8 refused m2 flagged on gate3 -> bit 4
        chk(2, 18, 16'h0010, "R8 m2 flag gate3");
        chk(1, 18, 16'h0000, "R8 m1 no flag");
        chk_irq(4'b0000, "R9 irq masked");
        // R9 masked enables
        put(2, 19, 16'h0110); step();
        chk(2, 19, 16'h0110, "R9 enable set");
        chk_irq(4'b0100, "R9 irq m2");
        put(2, 20, 16'h0100); step();
        chk(2, 20, 16'h0010, "R9 masked clear");
        chk(0, 19, 16'h0000, "R9 other master untouched");
        // R11 take clears own flag
        put(2, 3, 16'd3); step();
        chk(0, 3, 16'h0002, "R11 m2 owns gate3");
        chk(2, 18, 16'h0000, "R11 flag cleared on take");
        chk_irq(4'b0000, "R11 irq drops");
        // R5 same-cycle contention
        put(3, 9, 16'd4); put(0, 9, 16'd1); step();
        chk(1, 9, 16'h0000, "R5 lowest master wins");
        put(0, 12, 16'd1); step();
        chk(0, 12, 16'h0000, "R2 m0 owns gate12");
        // R6 single gate reset
        put(1, 16, 16'h09E2); step();
        chk(1, 16, 16'h0011, "R6 armed status");
        put(1, 16, 16'h091D); step();
        chk(2, 16, 16'h0001, "R6 done state hidden");
        chk(0, 9, 16'h00FF, "R6 gate9 freed");
        chk(0, 3, 16'h0002, "R6 gate3 kept");
        chk(3, 18, 16'h4000, "R8 m3 flag gate9 bit14");
        // R7 aborts
        put(1, 16, 16'h03E2); step();
        put(2, 16, 16'h031D); step();
        chk(1, 16, 16'h0001, "R7 other master aborts");
        chk(0, 3, 16'h0002, "R7 gate3 still held");
        put(1, 16, 16'h03E2); step();
        put(1, 16, 16'h0355); step();
        put(1, 16, 16'h031D); step();
        chk(1, 16, 16'h0001, "R7 wrong key aborts");
        chk(0, 3, 16'h0002, "R7 gate3 still held after bad key");
        // R6 reset all
        put(0, 16, 16'h40E2); step();
        chk(0, 16, 16'h0010, "R6 armed by m0");
        put(0, 16, 16'h401D); step();
        chk(0, 16, 16'h0000, "R6 status after all");
        chk(0, 3, 16'h00FF, "R6 all freed gate3");
        chk(0, 12, 16'h00FF, "R6 all freed gate12");
        chk(0, 15, 16'h00FF, "R6 all freed gate15");
        // R9 irq from flag
        put(3, 19, 16'h4000); step();
        chk_irq(4'b1000, "R9 m3 irq");
        // R10 notification reset for gate9
        put(2, 17, 16'h09E2); step();
        chk(3, 17, 16'h0012, "R10 armed status");
        chk(3, 16, 16'h0000, "R10 gate seq undisturbed");
        put(2, 17, 16'h091D); step();
        chk(3, 17, 16'h0002, "R10 done hidden");
        chk(3, 18, 16'h0000, "R10 m3 flag cleared");
        chk_irq(4'b0000, "R10 irq cleared");
        // R8 bit order gates 0 and 8
        put(0, 0, 16'd1); step();
        put(1, 0, 16'd2); step();
        chk(1, 0, 16'h0000, "R3 m0 keeps gate0");
        put(0, 0, 16'd0); step();
        chk(1, 18, 16'h0080, "R8 gate0 bit7");
        put(0, 8, 16'd1); step();
        put(2, 8, 16'd3); step();
        put(0, 8, 16'd0); step();
        chk(2, 18, 16'h8000, "R8 gate8 bit15");
        // R10 clear all
        put(3, 17, 16'h40E2); step();
        put(3, 17, 16'h401D); step();
        step();
        chk(1, 18, 16'h0000, "R10 all cleared m1");
        chk(2, 18, 16'h0000, "R10 all cleared m2");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule